// File: doc/BRIEF.md
# Counted-Loop Sequencer

This block runs a hardware counted loop. A pulse on `start` captures a first index and an end bound. The block then steps an index register from the first value up to, but not including, the bound. For each index value it hands one unit of work to external body logic. It signals completion with a one-cycle `done` pulse.

The design is split into two modules. A datapath holds the captured operands, the index register and an unsigned less-than comparator. A control state machine drives the datapath through a small struct of strobes and reads back one status bit, the comparator result. The body logic sees the current index on `index`, receives a one-cycle `bodyGo` request, and answers with `bodyDone` whenever its work is finished.

Every iteration spends a fixed number of cycles on sequencing:
- one cycle in which only the comparator is evaluated;
- one cycle for the request pulse;
- one cycle for the increment.

The index width is a parameter.

Top module: `loop_seq`

## Requirements
- R1: A synchronous active-high `rst` forces `done` and `bodyGo` low and clears `index` to 0. This holds even in the middle of a loop.
- R2: `startVal` and `termVal` are captured only on a clock edge where `start` is high and the block is idle. While a loop runs, new `start` pulses and changes to `startVal` or `termVal` have no effect on the iteration count, the index sequence or the timing.
- R3: After the capture edge, one load cycle follows. It places the captured start value in `index` before the first comparison, so the index seen with the first `bodyGo` equals the start value.
- R4: The comparison is unsigned. When the start value is below the bound, `bodyGo` is pulsed exactly (bound − start) times, each pulse one cycle wide, and the index at the n-th pulse (counting from 1) is start + n − 1. When the start value is greater than or equal to the bound, `bodyGo` never rises.
- R5: `bodyDone` is acted on only while the block waits for the body. When the block is idle with `bodyDone` held high and `start` low, it leaves `done`, `bodyGo` and `index` unchanged.
- R6: Each completed body advances `index` by exactly one. At `done`, `index` equals the bound if start < bound, and the start value otherwise.
- R7: Count the capture edge as edge 1. If each body answers `bodyDone` d cycles after entering its wait, `done` is high for exactly one cycle, following edge 3 + Σ(4 + d) over the iterations. An empty loop gives `done` after edge 3.
- R8: A bound equal to 2^N − 1 completes without the index wrapping: the final index is 2^N − 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a loop; honoured only when idle |
| startVal | input | N | First index value, captured with `start` |
| termVal | input | N | Exclusive end bound, captured with `start` |
| bodyGo | output | 1 | One-cycle request to the body logic for the current index |
| bodyDone | input | 1 | Body logic reports its work finished |
| index | output | N | Current loop index |
| done | output | 1 | One-cycle pulse when the loop exits |

## Verification
Every output of this block is a decode of registered state. So `index`, `bodyGo` and `done` are all sampled on the falling edge after the rising edge that produced them, never at the rising edge itself.

The bench counts rising edges from the capture edge. It expects `done` after edge 3 + K·(4 + d), where K is the iteration count and d is the reply delay. A bench-side responder raises `bodyDone` in the (d+1)-th wait cycle after each `bodyGo`.

The index is compared against start + n at each `bodyGo`. The `done` pulse is checked on the falling edge where it appears and again one cycle later.

// File: rtl/loop_seq_pkg.sv
package loop_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_INIT,
    ST_COMP,
    ST_GO,
    ST_BODY,
    ST_INC,
    ST_EXIT
  } seqState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;   // latch start value and bound
    logic loadIdx;   // index <= captured start value
    logic incIdx;    // index <= index + 1
  } dpCtrl_t;

endpackage

// File: rtl/loop_seq_dp.sv
module loop_seq_dp
  import loop_seq_pkg::*;
#(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  dpCtrl_t      ctrl,
  input  logic [N-1:0] startVal,
  input  logic [N-1:0] termVal,
  output logic [N-1:0] index,
  output logic         lessThan
);

  localparam logic [N-1:0] ONE = {{(N-1){1'b0}}, 1'b1};

  logic [N-1:0] startQ;
  logic [N-1:0] termQ;
  logic [N-1:0] idxQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      startQ <= '0;
      termQ  <= '0;
    end else if (ctrl.capture) begin
      startQ <= startVal;
      termQ  <= termVal;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)               idxQ <= '0;
    else if (ctrl.loadIdx) idxQ <= startQ;
    else if (ctrl.incIdx)  idxQ <= idxQ + ONE;
  end

  // unsigned magnitude status for the control unit
  always_comb lessThan = (idxQ < termQ);

  assign index = idxQ;

endmodule

// File: rtl/loop_seq_ctrl.sv
module loop_seq_ctrl
  import loop_seq_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    start,
  input  logic    lessThan,
  input  logic    bodyDone,
  output dpCtrl_t ctrl,
  output logic    bodyGo,
  output logic    done
);

  seqState_e stateQ;
  seqState_e stateD;

  always_ff @(posedge clk) begin
    if (rst) stateQ <= ST_IDLE;
    else     stateQ <= stateD;
  end

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      ST_IDLE: if (start) stateD = ST_INIT;
      ST_INIT: stateD = ST_COMP;
      ST_COMP: stateD = lessThan ? ST_GO : ST_EXIT;
      ST_GO:   stateD = ST_BODY;
      ST_BODY: if (bodyDone) stateD = ST_INC;
      ST_INC:  stateD = ST_COMP;
      ST_EXIT: stateD = ST_IDLE;
      default: stateD = ST_IDLE;
    endcase
  end

  always_comb begin
    ctrl         = '0;
    ctrl.capture = (stateQ == ST_IDLE) && start;
    ctrl.loadIdx = (stateQ == ST_INIT);
    ctrl.incIdx  = (stateQ == ST_INC);
  end

  assign bodyGo = (stateQ == ST_GO);
  assign done   = (stateQ == ST_EXIT);

endmodule

// File: rtl/loop_seq.sv
module loop_seq
  import loop_seq_pkg::*;
#(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [N-1:0] startVal,
  input  logic [N-1:0] termVal,
  output logic         bodyGo,
  input  logic         bodyDone,
  output logic [N-1:0] index,
  output logic         done
);

  dpCtrl_t ctrl;
  logic    lessThan;

  loop_seq_ctrl ctrl_i (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .lessThan (lessThan),
    .bodyDone (bodyDone),
    .ctrl     (ctrl),
    .bodyGo   (bodyGo),
    .done     (done)
  );

  loop_seq_dp #(.N(N)) dp_i (
    .clk      (clk),
    .rst      (rst),
    .ctrl     (ctrl),
    .startVal (startVal),
    .termVal  (termVal),
    .index    (index),
    .lessThan (lessThan)
  );

endmodule

// File: rtl/loop_seq_chk.sv
module loop_seq_chk
  import loop_seq_pkg::*;
#(
  parameter int N = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         bodyGo,
  input logic         done,
  input logic [N-1:0] index,
  input logic         lessThan,
  input dpCtrl_t      ctrl
);

  AST_GO_SINGLE: assert property (@(posedge clk) disable iff (rst)
    bodyGo |=> !bodyGo);                                        // R4

  AST_GO_NEEDS_LESS: assert property (@(posedge clk) disable iff (rst)
    bodyGo |-> $past(lessThan));                                // R4

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);                                            // R7

  AST_DONE_NOT_LESS: assert property (@(posedge clk) disable iff (rst)
    done |-> !$past(lessThan));                                 // R6

  AST_INDEX_STEP: assert property (@(posedge clk) disable iff (rst)
    ctrl.incIdx |=> (index == $past(index) + 1'b1));            // R6

  AST_INDEX_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!ctrl.loadIdx && !ctrl.incIdx) |=> $stable(index));        // R5

  AST_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
    ctrl.incIdx |-> (index != {N{1'b1}}));                      // R8

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(ctrl.loadIdx && ctrl.incIdx));                            // R3

endmodule

bind loop_seq loop_seq_chk #(.N(N)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .bodyGo   (bodyGo),
  .done     (done),
  .index    (index),
  .lessThan (lessThan),
  .ctrl     (ctrl)
);

// File: tb/loop_seq_tb_top.sv
module loop_seq_tb_top;

  localparam int N        = 8;
  localparam int CLK_PER  = 10;
  localparam int NUM_VEC  = 10;
  localparam int WD_LIMIT = 150000;

  // {start, bound, body reply delay}
  localparam logic [19:0] VEC [NUM_VEC] = '{
    {8'd0,   8'd5,   4'd0},
    {8'd3,   8'd4,   4'd0},
    {8'd7,   8'd7,   4'd0},
    {8'd200, 8'd10,  4'd0},
    {8'd250, 8'd255, 4'd1},
    {8'd10,  8'd13,  4'd3},
    {8'd0,   8'd1,   4'd2},
    {8'd254, 8'd255, 4'd0},
    {8'd128, 8'd127, 4'd0},
    {8'd5,   8'd9,   4'd1}
  };

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic [N-1:0] startVal = '0;
  logic [N-1:0] termVal = '0;
  logic         bodyGo;
  logic         bodyDone = 1'b0;
  logic [N-1:0] index;
  logic         done;

  int  vecCount  = 0;
  int  failCount = 0;
  bit  finished  = 1'b0;

  int  respDelay = 0;
  bit  forceDone = 1'b0;
  bit  pending   = 1'b0;
  int  waitCnt   = 0;

  always #(CLK_PER/2) clk = ~clk;

  loop_seq #(.N(N)) dut_i (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .startVal (startVal),
    .termVal  (termVal),
    .bodyGo   (bodyGo),
    .bodyDone (bodyDone),
    .index    (index),
    .done     (done)
  );

  // body responder: raises bodyDone for one cycle, respDelay cycles late
  always @(negedge clk) begin
    if (rst) begin
      pending  = 1'b0;
      bodyDone = 1'b0;
    end else if (forceDone) begin
      bodyDone = 1'b1;
    end else if (bodyDone) begin
      bodyDone = 1'b0;
      pending  = 1'b0;
    end else if (bodyGo) begin
      pending = 1'b1;
      waitCnt = respDelay;
    end else if (pending) begin
      if (waitCnt == 0) bodyDone = 1'b1;
      else              waitCnt--;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vecCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic runLoop(input int a, input int b, input int d, input bit disturb);
    int  cycles  = 0;
    int  goCount = 0;
    int  expK    = (a < b) ? (b - a) : 0;
    int  expCyc  = 3 + expK * (4 + d);
    int  expIdx  = (a < b) ? b : a;
    bit  idxOk   = 1'b1;
    int  badIdx  = 0;
    int  badExp  = 0;
    @(negedge clk);
    respDelay = d;
    startVal  = a[N-1:0];
    termVal   = b[N-1:0];
    start     = 1'b1;
    while (1) begin
      @(posedge clk);
      cycles++;
      @(negedge clk);
      if (cycles == 1) start = 1'b0;
      if (disturb && cycles == 4) begin
        start    = 1'b1;
        startVal = ~a[N-1:0];
        termVal  = ~b[N-1:0];
      end
      if (disturb && cycles == 5) start = 1'b0;
      if (bodyGo) begin
        if (int'(index) != a + goCount && idxOk) begin
          idxOk  = 1'b0;
          badIdx = int'(index);
          badExp = a + goCount;
        end
        goCount++;
      end
      if (done || cycles > 5000) break;
    end
    start = 1'b0;
    chk(idxOk, "R3/R4 index at bodyGo", badIdx, badExp);
    chk(goCount == expK, "R4 body count", goCount, expK);
    chk(cycles == expCyc, "R7 done latency", cycles, expCyc);
    chk(int'(index) == expIdx, "R6 final index", int'(index), expIdx);
    if (disturb) chk(goCount == expK && cycles == expCyc, "R2 start ignored when busy",
                     cycles, expCyc);
    @(negedge clk);
    chk(done == 1'b0, "R7 done one cycle", int'(done), 0);
  endtask

  // watchdog
  initial begin
    repeat (WD_LIMIT) @(posedge clk);
    if (!finished) begin
      failCount++;
      $display("FAIL watchdog actual=%0d expected=%0d", WD_LIMIT, 0);
      $display("  == %0d vectors applied, %0d miscompares ==", vecCount, failCount);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1: state held in reset
    chk(done == 1'b0,   "R1 reset done",   int'(done),   0);
    chk(bodyGo == 1'b0, "R1 reset bodyGo", int'(bodyGo), 0);
    chk(index == '0,    "R1 reset index",  int'(index),  0);
    rst = 1'b0;

    // R5: idle with bodyDone high
    @(negedge clk);
    forceDone = 1'b1;
    begin
      bit moved = 1'b0;
      for (int k = 0; k < 6; k++) begin
        @(negedge clk);
        if (done || bodyGo || index != '0) moved = 1'b1;
      end
      chk(!moved, "R5 bodyDone ignored in idle", int'(moved), 0);
    end
    forceDone = 1'b0;
    @(negedge clk);

    // vector walk
    for (int v = 0; v < NUM_VEC; v++) begin
      runLoop(int'(VEC[v][19:12]), int'(VEC[v][11:4]), int'(VEC[v][3:0]), 1'b0);
    end

    // R2: disturbed runs
    runLoop(2, 6, 0, 1'b1);
    runLoop(40, 43, 2, 1'b1);

    // R8: full-range bound, no wrap
    runLoop(251, 255, 0, 1'b0);
    chk(index == 8'hFF, "R8 no wrap at max bound", int'(index), 255);

    // R1: reset in the middle of a loop
    @(negedge clk);
    respDelay = 5;
    startVal  = 8'd1;
    termVal   = 8'd9;
    start     = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (7) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk(index == '0 && !done && !bodyGo, "R1 mid-loop reset", int'(index), 0);
    rst = 1'b0;
    @(negedge clk);
    runLoop(4, 6, 0, 1'b0);

    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vecCount, failCount);
    $finish;
  end

endmodule